// File: doc/BRIEF.md
# Periodic Real-Time Wakeup Timer

This block is a low-rate interval timer used to wake a system at regular intervals. It counts ticks from one of two slow sources: an internal 1 kHz tick or an external reference tick. When a chosen number of ticks has passed, it sets a sticky status flag. The interrupt request line is that flag masked by a local enable. When the system is in one of its stop modes, each expiry also produces a one-clock wakeup pulse.

Software controls the timer through one 8-bit register. A 3-bit period code picks one of seven intervals; code zero switches the timer off. The status flag is read-only. Software clears it by writing 1 to a separate acknowledge bit, and that bit always reads back as 0. A power-mode input limits which tick source may drive the counter in each stop mode. In the lighter stop mode, two oscillator qualifiers must also be asserted before the external tick is accepted.

The tick inputs are one-clock strobes that are synchronous to `clk`. A write and its effects take hold at the clock edge on which `reg_we` is high.

Top module: `periodic_wake_timer`

## Requirements
- R1: Period codes 1 to 7 (bits [2:0] of the register) give 8, 32, 64, 128, 256, 512 and 1024 accepted ticks. The flag (bit 6) reads 1 in the clock after the tick that completes the period.
- R2: With period code 0, the counter stays idle. The flag never sets, and no wakeup pulse is produced.
- R3: Writes to bit 6 have no effect on the flag. Writing 1 to bit 4 clears the flag, and bit 4 always reads 0. If an expiry and an acknowledge happen in the same clock, the expiry wins.
- R4: `irq` is high exactly when the flag and the enable (bit 3) are both 1. The flag still sets while the enable is 0.
- R5: Bit 5 selects the tick source: 0 for the internal tick, 1 for the external tick. In run mode (`pwr_mode` = 0), either source counts, and ticks on the source that is not selected are ignored.
- R6: In deep stop (`pwr_mode` = 2 or 3), only the internal tick counts. If the external source is selected in deep stop, the counter holds and the flag does not set.
- R7: In light stop (`pwr_mode` = 1), the external tick counts only while `osc_stop_en` and `osc_low_range` are both 1. The internal tick always counts in light stop.
- R8: A write that changes the period code clears the counter, so the next expiry comes one full new period later. A write that leaves the code unchanged does not disturb the count.
- R9: Once set, the flag stays set across further expiries until it is acknowledged. Nothing counts the extra expiries.
- R10: In either stop mode, `wake` pulses high for one clock on each expiry. In run mode, it never pulses.
- R11: After reset, the register reads 0 and `irq` and `wake` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_int | input | 1 | Internal 1 kHz tick strobe |
| tick_ext | input | 1 | External reference tick strobe |
| pwr_mode | input | 2 | 0 = run, 1 = light stop, 2 or 3 = deep stop |
| osc_stop_en | input | 1 | External oscillator kept running in stop |
| osc_low_range | input | 1 | External oscillator in low-range setting |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data: [2:0] period, [3] enable, [4] acknowledge, [5] source |
| reg_rdata | output | 8 | Read data: [2:0] period, [3] enable, [4] 0, [5] source, [6] flag, [7] 0 |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | One-clock wakeup pulse on expiry in stop modes |

## Verification
A wrong count value can only show up at the ports as a flag that rises on the wrong tick. In the worst case, for code 7, that is up to 1024 ticks after the fault. For this reason, the long periods are checked right up to their final tick, and the counter is always cleared first.

A wrong flag, enable or source bit appears in the read data and on `irq` in the very next clock. A fault in the source gating only shows once a full period has passed in the wrong mode, so every mode and qualifier combination runs at least one complete short period.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
    localparam int SEL_W   = 3;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = SEL_W + 7;
    localparam int F_EN    = 3;
    localparam int F_ACK   = 4;
    localparam int F_SRC   = 5;
    localparam int F_FLAG  = 6;

    localparam logic [1:0] PM_RUN   = 2'd0;
    localparam logic [1:0] PM_LIGHT = 2'd1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             en;
        logic             src;
        logic             flag;
        logic             wake;
    } ctl_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    function automatic logic [CNT_W:0] period_ticks(input logic [SEL_W-1:0] code);
        logic [CNT_W:0] p;
        if (code == '0)
            p = '0;
        else if (code == SEL_W'(1))
            p = (CNT_W+1)'(8);
        else
            p = (CNT_W+1)'(1) << (int'(code) + 3);
        return p;
    endfunction
endpackage

// File: rtl/pwt_src_gate.sv
module pwt_src_gate
    import pwt_pkg::*;
(
    input  logic       tick_int,
    input  logic       tick_ext,
    input  logic       src_ext,
    input  logic [1:0] pwr_mode,
    input  logic       osc_stop_en,
    input  logic       osc_low_range,
    output logic       tick_ok
);
    logic allowed;

    always_comb begin
        if (!src_ext)
            allowed = 1'b1;
        else if (pwr_mode == PM_RUN)
            allowed = 1'b1;
        else if (pwr_mode == PM_LIGHT)
            allowed = osc_stop_en & osc_low_range;
        else
            allowed = 1'b0;
        tick_ok = allowed & (src_ext ? tick_ext : tick_int);
    end
endmodule

// File: rtl/pwt_divider.sv
module pwt_divider
    import pwt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             clear,
    input  logic             tick,
    output logic             expire
);
    div_t st_d, st_q;
    logic [CNT_W-1:0] last;

    assign last = CNT_W'(period_ticks(sel) - 1'b1);

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (clear || sel == '0) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == last) begin
                st_d.cnt = '0;
                expire   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/periodic_wake_timer.sv
module periodic_wake_timer
    import pwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_int,
    input  logic              tick_ext,
    input  logic [1:0]        pwr_mode,
    input  logic              osc_stop_en,
    input  logic              osc_low_range,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              wake
);
    ctl_t ctl_d, ctl_q;
    logic tick_ok;
    logic expire;
    logic sel_change;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_W-1:F_FLAG];
    assign sel_change   = reg_we && (reg_wdata[SEL_W-1:0] != ctl_q.sel);

    pwt_src_gate u_gate (
        .tick_int      (tick_int),
        .tick_ext      (tick_ext),
        .src_ext       (ctl_q.src),
        .pwr_mode      (pwr_mode),
        .osc_stop_en   (osc_stop_en),
        .osc_low_range (osc_low_range),
        .tick_ok       (tick_ok)
    );

    pwt_divider u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (ctl_q.sel),
        .clear  (sel_change),
        .tick   (tick_ok),
        .expire (expire)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.wake = expire && (pwr_mode != PM_RUN);
        if (reg_we) begin
            ctl_d.sel = reg_wdata[SEL_W-1:0];
            ctl_d.en  = reg_wdata[F_EN];
            ctl_d.src = reg_wdata[F_SRC];
            if (reg_wdata[F_ACK])
                ctl_d.flag = 1'b0;
        end
        if (expire)
            ctl_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= '0;
        else
            ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata              = '0;
        reg_rdata[SEL_W-1:0]   = ctl_q.sel;
        reg_rdata[F_EN]        = ctl_q.en;
        reg_rdata[F_SRC]       = ctl_q.src;
        reg_rdata[F_FLAG]      = ctl_q.flag;
    end

    assign irq  = ctl_q.flag & ctl_q.en;
    assign wake = ctl_q.wake;
endmodule

// File: rtl/pwt_checker.sv
module pwt_checker
    import pwt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        pwr_mode,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic              wake
);
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[SEL_W-1:0] == '0) |=> !$rose(reg_rdata[F_FLAG]));

    p_ack_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wdata[F_ACK]) |=> !reg_rdata[F_ACK]);

    p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[F_EN] |-> !irq);

    p_deep_ext_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode[1] && reg_rdata[F_SRC]) |=> !$rose(reg_rdata[F_FLAG]));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[F_FLAG] && !(reg_we && reg_wdata[F_ACK])) |=> reg_rdata[F_FLAG]);

    p_wake_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ($past(pwr_mode) != PM_RUN));

    p_wake_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> reg_rdata[F_FLAG]);
endmodule

bind periodic_wake_timer pwt_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_mode  (pwr_mode),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .wake      (wake)
);

// File: tb/periodic_wake_timer_test.sv
`timescale 1ns/1ps
module periodic_wake_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_int = 1'b0;
    logic       tick_ext = 1'b0;
    logic [1:0] pwr_mode = 2'd0;
    logic       osc_stop_en = 1'b0;
    logic       osc_low_range = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       wake;

    int total = 0;
    int bad = 0;
    int wakes = 0;
    int cycles = 0;

    periodic_wake_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .tick_ext(tick_ext),
        .pwr_mode(pwr_mode), .osc_stop_en(osc_stop_en), .osc_low_range(osc_low_range),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .wake(wake)
    );

    always #4 clk = ~clk;

    // behavioural reference model
    int m_sel = 0, m_en = 0, m_src = 0, m_flag = 0, m_cnt = 0, m_wake = 0;

    function automatic int ref_period(int c);
        case (c)
            1: return 8;
            2: return 32;
            3: return 64;
            4: return 128;
            5: return 256;
            6: return 512;
            7: return 1024;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_en = 0; m_src = 0; m_flag = 0; m_cnt = 0; m_wake = 0;
        end else begin
            bit ok, tk, hit;
            tk = m_src ? tick_ext : tick_int;
            if (pwr_mode == 2'd0) ok = 1;
            else if (pwr_mode == 2'd1) ok = !m_src || (osc_stop_en && osc_low_range);
            else ok = !m_src;
            hit = 0;
            if (reg_we && int'(reg_wdata[2:0]) != m_sel) m_cnt = 0;
            else if (m_sel == 0) m_cnt = 0;
            else if (ok && tk) begin
                m_cnt++;
                if (m_cnt == ref_period(m_sel)) begin m_cnt = 0; hit = 1; end
            end
            m_wake = (hit && pwr_mode != 2'd0) ? 1 : 0;
            if (reg_we) begin
                if (reg_wdata[4]) m_flag = 0;
                m_sel = int'(reg_wdata[2:0]);
                m_en  = int'(reg_wdata[3]);
                m_src = int'(reg_wdata[5]);
            end
            if (hit) m_flag = 1;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 model rdata", int'(reg_rdata),
                  (m_flag << 6) | (m_src << 5) | (m_en << 3) | m_sel);
            check("R4 model irq", int'(irq), m_flag & m_en);
            check("R10 model wake", int'(wake), m_wake);
        end
    end

    task automatic wr(input logic [7:0] v);
        @(negedge clk) begin reg_we = 1'b1; reg_wdata = v; end
        @(negedge clk) begin reg_we = 1'b0; reg_wdata = 8'h00; end
    endtask

    function automatic logic [7:0] cfg(int sel, int en, int src);
        return 8'(sel | (en << 3) | 16 | (src << 5));
    endfunction

    task automatic setup(input logic [7:0] v);
        wr(8'h10);
        wr(v);
    endtask

    task automatic pulse(input bit ext, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) begin if (ext) tick_ext = 1'b1; else tick_int = 1'b1; end
            @(negedge clk) begin
                tick_ext = 1'b0; tick_int = 1'b0;
                if (wake) wakes++;
            end
        end
    endtask

    function automatic int flag();
        return int'(reg_rdata[6]);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset rdata", int'(reg_rdata), 0);
        check("R11 reset irq", int'(irq), 0);
        check("R11 reset wake", int'(wake), 0);

        setup(cfg(1, 1, 0));
        pulse(0, 7);  check("R1 code1 before 8", flag(), 0);
        pulse(0, 1);  check("R1 code1 at 8", flag(), 1);
        check("R4 irq enabled", int'(irq), 1);

        pulse(0, 8);  check("R9 flag stays set", flag(), 1);
        wr(cfg(1, 1, 0)); check("R3 ack clears", flag(), 0);
        wr(8'h49);    check("R3 write bit6 ignored", flag(), 0);
        check("R3 ack bit reads 0", int'(reg_rdata[4]), 0);

        setup(cfg(1, 0, 0));
        pulse(0, 8);  check("R4 masked flag sets", flag(), 1);
        check("R4 masked irq low", int'(irq), 0);

        setup(cfg(0, 1, 0)); wakes = 0;
        pulse(0, 40); check("R2 off run", flag(), 0);
        @(negedge clk) pwr_mode = 2'd2;
        pulse(0, 40); check("R2 off deep flag", flag(), 0);
        check("R2 off deep wake", wakes, 0);
        @(negedge clk) pwr_mode = 2'd0;

        setup(cfg(2, 1, 0));
        pulse(0, 31); check("R1 code2 before 32", flag(), 0);
        pulse(0, 1);  check("R1 code2 at 32", flag(), 1);
        setup(cfg(4, 1, 0));
        pulse(0, 127); check("R1 code4 before 128", flag(), 0);
        pulse(0, 1);   check("R1 code4 at 128", flag(), 1);
        setup(cfg(7, 1, 0));
        pulse(0, 1023); check("R1 code7 before 1024", flag(), 0);
        pulse(0, 1);    check("R1 code7 at 1024", flag(), 1);

        setup(cfg(1, 1, 0));
        pulse(0, 5); wr(cfg(2, 1, 0));
        pulse(0, 31); check("R8 change restarts", flag(), 0);
        pulse(0, 1);  check("R8 change full period", flag(), 1);
        setup(cfg(2, 1, 0));
        pulse(0, 5); wr(cfg(2, 1, 0));
        pulse(0, 26); check("R8 same code keeps count", flag(), 0);
        pulse(0, 1);  check("R8 same code expiry", flag(), 1);

        setup(cfg(1, 1, 1));
        pulse(0, 10); check("R5 ext sel ignores int", flag(), 0);
        pulse(1, 8);  check("R5 ext counts in run", flag(), 1);
        setup(cfg(1, 1, 0));
        pulse(1, 10); check("R5 int sel ignores ext", flag(), 0);

        @(negedge clk) pwr_mode = 2'd2;
        setup(cfg(1, 1, 1));
        pulse(1, 8);  check("R6 deep ext holds", flag(), 0);
        setup(cfg(1, 1, 0)); wakes = 0;
        pulse(0, 8);  check("R6 deep int counts", flag(), 1);
        check("R10 deep one wake", wakes, 1);

        @(negedge clk) begin pwr_mode = 2'd1; osc_stop_en = 1'b0; osc_low_range = 1'b1; end
        setup(cfg(1, 1, 1));
        pulse(1, 8);  check("R7 light no osc_en", flag(), 0);
        @(negedge clk) begin osc_stop_en = 1'b1; osc_low_range = 1'b0; end
        setup(cfg(1, 1, 1));
        pulse(1, 8);  check("R7 light no low range", flag(), 0);
        @(negedge clk) begin osc_low_range = 1'b1; end
        setup(cfg(1, 1, 1));
        pulse(1, 8);  check("R7 light qualified ext", flag(), 1);
        @(negedge clk) begin osc_stop_en = 1'b0; osc_low_range = 1'b0; end
        setup(cfg(1, 1, 0)); wakes = 0;
        pulse(0, 16); check("R7 light int counts", flag(), 1);
        check("R10 light two wakes", wakes, 2);

        @(negedge clk) pwr_mode = 2'd0;
        setup(cfg(1, 1, 0)); wakes = 0;
        pulse(0, 16); check("R10 run no wake", wakes, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                total++; bad++;
                $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end
endmodule